// File: doc/BRIEF.md
# DMA Channel Interrupt and Error Status Unit

This block collects the per-channel events of a multi-channel DMA engine and turns them into software-visible status and two interrupt lines. For every channel it keeps a completion flag and four error flags (burst timeout, request timeout, transfer error and buffer overflow). Each flag stays set until software clears it by writing a one to its bit. A per-channel mask decides which completion flags reach the normal interrupt line. Any error flag drives the error interrupt line, whatever the mask holds.

The channel logic delivers one-cycle event pulses. The unit records them only while the module enable bit is set. A control register holds that enable bit and a module-reset request bit. The reset request bit wipes all status, masks every channel and then drops back to zero on its own. Software reaches all registers through a plain register port: a write strobe, a read strobe, a byte offset and 32-bit data. Read data returns one cycle after the read strobe.

Top module: `dma_irq_status_unit`

## Requirements
- R1: After the synchronous reset input, every status register reads 0, the mask register reads all ones in its 16 channel bits, the control register reads 0, and `irq_norm`, `irq_err` and `mod_en` are 0.
- R2: When the enable bit (bit 0 of the control register at offset 0x00) is 1, a pulse on channel n of an event input sets bit n of its status register. The registers are: completion at 0x04, burst timeout at 0x0C, request timeout at 0x10, transfer error at 0x14 and buffer overflow at 0x18. The bit stays set after the pulse ends.
- R3: While the enable bit is 0, event pulses change no status bit.
- R4: A write to any status register clears each bit written as one. It leaves each bit written as zero unchanged, and it can never set a bit.
- R5: If an event pulse and a clearing write hit the same bit in the same cycle, the bit remains set. Other bits cleared by that write still clear.
- R6: The mask register at offset 0x08 is read/write, with channel n at bit n. A 1 blocks that channel from the normal interrupt. `irq_norm` is a register that holds, one cycle later, the OR of all completion bits whose mask bit is 0.
- R7: `irq_err` is a register that holds, one cycle later, the OR of every bit of the four error registers. The mask has no effect on it.
- R8: Writing 1 to bit 1 of the control register makes that bit read 1 for exactly one cycle. In the next cycle all five status registers clear and the mask becomes all ones. Event pulses in that cycle are dropped. The enable bit keeps the value written.
- R9: A read strobe at a clock edge returns, after that edge, the register value from before the edge on `reg_rdata`, with `reg_rvalid` high for one cycle. Offsets that hold no register read 0, and writes to them change nothing.
- R10: Status and mask bits use only the low 16 bits. Upper data bits read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| ev_done | input | 16 | Per-channel completion pulses |
| ev_burst_to | input | 16 | Per-channel burst timeout pulses |
| ev_req_to | input | 16 | Per-channel request timeout pulses |
| ev_xfer_err | input | 16 | Per-channel transfer error pulses |
| ev_buf_ovf | input | 16 | Per-channel buffer overflow pulses |
| mod_en | output | 1 | Module enable bit of the control register |
| irq_norm | output | 1 | Unmasked completion interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
Most internal faults in this unit show up at the ports within two cycles. A flag that fails to set, sticks or clears the wrong bit shows up on the next read of its register. It also shows up one cycle later on `irq_norm` or `irq_err`, because those lines are registered straight from the stored bits. A reset request that never drops, or that clears too little, shows up in the control readback and in the mask reading all ones. The stimulus therefore pairs every state change with a read-back and an interrupt sample: single bits, both end channels, the clear-versus-event collision and accesses to unmapped offsets. A pseudo-random mix of events and clears follows.

// File: rtl/dmastat_pkg.sv
package dmastat_pkg;
  localparam int unsigned ERR_KINDS = 4;

  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_DONE = 8'h04;
  localparam logic [7:0] OFF_MASK = 8'h08;
  localparam logic [7:0] OFF_ERR0 = 8'h0C;

  typedef enum logic [1:0] {
    ERR_BURST = 2'd0,
    ERR_REQ   = 2'd1,
    ERR_XFER  = 2'd2,
    ERR_BUF   = 2'd3
  } err_kind_e;

  // error banks sit one word apart, starting at OFF_ERR0
  function automatic logic [7:0] err_offset(input int unsigned k);
    return OFF_ERR0 + 8'(k << 2);
  endfunction
endpackage

// File: rtl/dmastat_w1c_bank.sv
module dmastat_w1c_bank #(
  parameter int unsigned NCH = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           soft_clr,
  input  logic [NCH-1:0] ev,
  input  logic           clr_we,
  input  logic [NCH-1:0] clr_bits,
  output logic [NCH-1:0] q
);
  logic [NCH-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (rst || soft_clr) q <= '0;
    else                 q <= (q & ~clr_eff) | ev;
  end

  // R5: a pulse always lands, even against a clear of the same bit
  a_r5_event_wins: assert property (@(posedge clk) disable iff (rst)
    (!soft_clr && (|ev)) |=> ((q & $past(ev)) == $past(ev)));

  // R4: no bit appears without an event
  a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((q & ~$past(q) & ~$past(ev)) == '0));

  // R8: module reset request empties the bank
  a_r8_bank_cleared: assert property (@(posedge clk) disable iff (rst)
    soft_clr |=> (q == '0));
endmodule

// File: rtl/dmastat_ctl.sv
module dmastat_ctl #(
  parameter int unsigned NCH = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_ctl,
  input  logic           wr_mask,
  input  logic [1:0]     ctl_wdata,
  input  logic [NCH-1:0] mask_wdata,
  output logic           en,
  output logic           rst_pend,
  output logic [NCH-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 1'b0;
      rst_pend <= 1'b0;
      mask     <= '1;
    end else begin
      if (wr_ctl) en <= ctl_wdata[0];
      rst_pend <= wr_ctl & ctl_wdata[1];
      if (rst_pend)     mask <= '1;
      else if (wr_mask) mask <= mask_wdata;
    end
  end

  // R8: reset request lasts one cycle unless rewritten
  a_r8_self_clear: assert property (@(posedge clk) disable iff (rst)
    rst_pend |=> (!rst_pend || $past(wr_ctl && ctl_wdata[1])));

  // R8: reset request masks every channel
  a_r8_mask_all: assert property (@(posedge clk) disable iff (rst)
    rst_pend |=> (mask == '1));

  // R6: mask only moves by a write or a reset request
  a_r6_mask_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr_mask && !rst_pend) |=> $stable(mask));
endmodule

// File: rtl/dmastat_irq_out.sv
module dmastat_irq_out #(
  parameter int unsigned NCH   = 16,
  parameter int unsigned NKIND = 4,
  localparam int unsigned EW   = NCH * NKIND
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] done,
  input  logic [NCH-1:0] mask,
  input  logic [EW-1:0]  err_flat,
  output logic           irq_norm,
  output logic           irq_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_norm <= 1'b0;
      irq_err  <= 1'b0;
    end else begin
      irq_norm <= |(done & ~mask);
      irq_err  <= |err_flat;
    end
  end

  // R6: a fully masked completion bank never raises the normal line
  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (mask == '1) |=> !irq_norm);

  // R7: error line follows any stored error a cycle later
  a_r7_err_line: assert property (@(posedge clk) disable iff (rst)
    (|err_flat) |=> irq_err);
endmodule

// File: rtl/dma_irq_status_unit.sv
module dma_irq_status_unit
  import dmastat_pkg::*;
#(
  parameter int unsigned NCH = 16,
  parameter int unsigned DW  = 32,
  parameter int unsigned AW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [AW-1:0]  reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           reg_rvalid,
  input  logic [NCH-1:0] ev_done,
  input  logic [NCH-1:0] ev_burst_to,
  input  logic [NCH-1:0] ev_req_to,
  input  logic [NCH-1:0] ev_xfer_err,
  input  logic [NCH-1:0] ev_buf_ovf,
  output logic           mod_en,
  output logic           irq_norm,
  output logic           irq_err
);
  localparam int unsigned EW = NCH * ERR_KINDS;

  logic           en, rst_pend;
  logic [NCH-1:0] mask, done_q;
  logic [EW-1:0]  err_flat;
  logic [EW-1:0]  err_ev_flat;
  logic [DW-1:0]  rd_mux;
  logic           wr_ctl, wr_mask, wr_done;
  logic           unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[DW-1:NCH];

  assign wr_ctl  = reg_wr && (reg_addr == AW'(OFF_CTRL));
  assign wr_mask = reg_wr && (reg_addr == AW'(OFF_MASK));
  assign wr_done = reg_wr && (reg_addr == AW'(OFF_DONE));

  assign err_ev_flat[int'(ERR_BURST)*NCH +: NCH] = ev_burst_to;
  assign err_ev_flat[int'(ERR_REQ)*NCH   +: NCH] = ev_req_to;
  assign err_ev_flat[int'(ERR_XFER)*NCH  +: NCH] = ev_xfer_err;
  assign err_ev_flat[int'(ERR_BUF)*NCH   +: NCH] = ev_buf_ovf;

  dmastat_ctl #(.NCH(NCH)) u_ctl (
    .clk(clk), .rst(rst),
    .wr_ctl(wr_ctl), .wr_mask(wr_mask),
    .ctl_wdata(reg_wdata[1:0]), .mask_wdata(reg_wdata[NCH-1:0]),
    .en(en), .rst_pend(rst_pend), .mask(mask)
  );

  dmastat_w1c_bank #(.NCH(NCH)) u_done (
    .clk(clk), .rst(rst), .soft_clr(rst_pend),
    .ev(ev_done & {NCH{en}}),
    .clr_we(wr_done), .clr_bits(reg_wdata[NCH-1:0]),
    .q(done_q)
  );

  for (genvar k = 0; k < ERR_KINDS; k++) begin : g_err
    logic wr_this;
    assign wr_this = reg_wr && (reg_addr == AW'(err_offset(k)));
    dmastat_w1c_bank #(.NCH(NCH)) u_bank (
      .clk(clk), .rst(rst), .soft_clr(rst_pend),
      .ev(err_ev_flat[k*NCH +: NCH] & {NCH{en}}),
      .clr_we(wr_this), .clr_bits(reg_wdata[NCH-1:0]),
      .q(err_flat[k*NCH +: NCH])
    );
  end

  dmastat_irq_out #(.NCH(NCH), .NKIND(ERR_KINDS)) u_irq (
    .clk(clk), .rst(rst),
    .done(done_q), .mask(mask), .err_flat(err_flat),
    .irq_norm(irq_norm), .irq_err(irq_err)
  );

  always_comb begin
    rd_mux = '0;
    if (reg_addr == AW'(OFF_CTRL)) rd_mux = DW'({rst_pend, en});
    if (reg_addr == AW'(OFF_DONE)) rd_mux = DW'(done_q);
    if (reg_addr == AW'(OFF_MASK)) rd_mux = DW'(mask);
    for (int k = 0; k < ERR_KINDS; k++)
      if (reg_addr == AW'(err_offset(k))) rd_mux = DW'(err_flat[k*NCH +: NCH]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end

  assign mod_en = en;

  // R9: read data valid exactly one cycle after each strobe
  a_r9_rvalid_follows: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid);
  a_r9_rvalid_quiet: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> !reg_rvalid);

  // R3: with the module disabled no completion bit rises
  a_r3_disabled_no_set: assert property (@(posedge clk) disable iff (rst)
    !mod_en |=> ((done_q & ~$past(done_q)) == '0));
endmodule

// File: tb/tb_dma_irq_status_unit.sv
module tb_dma_irq_status_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr, reg_rd;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic [NCH-1:0] ev_done, ev_burst_to, ev_req_to, ev_xfer_err, ev_buf_ovf;
  logic        mod_en, irq_norm, irq_err;

  dma_irq_status_unit dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .ev_done(ev_done), .ev_burst_to(ev_burst_to),
    .ev_req_to(ev_req_to), .ev_xfer_err(ev_xfer_err), .ev_buf_ovf(ev_buf_ovf),
    .mod_en(mod_en), .irq_norm(irq_norm), .irq_err(irq_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done_run = 1'b0;

  // model state
  logic [NCH-1:0] m_done, m_mask;
  logic [NCH-1:0] m_err [4];
  logic           m_en, m_rstp;

  // scoreboard
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h00: return {30'd0, m_rstp, m_en};
      8'h04: return {16'd0, m_done};
      8'h08: return {16'd0, m_mask};
      8'h0C: return {16'd0, m_err[0]};
      8'h10: return {16'd0, m_err[1]};
      8'h14: return {16'd0, m_err[2]};
      8'h18: return {16'd0, m_err[3]};
      default: return 32'd0;
    endcase
  endfunction

  task automatic idle_inputs();
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    ev_done = 0; ev_burst_to = 0; ev_req_to = 0; ev_xfer_err = 0; ev_buf_ovf = 0;
  endtask

  // apply currently driven inputs for one clock, keep model in step
  task automatic tick(input string tag);
    logic [NCH-1:0] evs [5];
    logic [NCH-1:0] n_done, n_mask;
    logic [NCH-1:0] n_err [4];
    logic           n_en, n_rstp;
    if (reg_rd) begin
      exp_q.push_back(model_read(reg_addr));
      tag_q.push_back(tag);
    end
    evs[0] = ev_done & {NCH{m_en}};
    evs[1] = ev_burst_to & {NCH{m_en}};
    evs[2] = ev_req_to & {NCH{m_en}};
    evs[3] = ev_xfer_err & {NCH{m_en}};
    evs[4] = ev_buf_ovf & {NCH{m_en}};
    n_en = (reg_wr && reg_addr == 8'h00) ? reg_wdata[0] : m_en;
    n_rstp = reg_wr && reg_addr == 8'h00 && reg_wdata[1];
    if (m_rstp) begin
      n_done = '0; n_mask = '1;
      for (int k = 0; k < 4; k++) n_err[k] = '0;
    end else begin
      n_done = (m_done & ~((reg_wr && reg_addr == 8'h04) ? reg_wdata[15:0] : 16'h0)) | evs[0];
      for (int k = 0; k < 4; k++)
        n_err[k] = (m_err[k] & ~((reg_wr && reg_addr == 8'(8'h0C + 4*k)) ? reg_wdata[15:0] : 16'h0)) | evs[k+1];
      n_mask = (reg_wr && reg_addr == 8'h08) ? reg_wdata[15:0] : m_mask;
    end
    @(posedge clk);
    m_done = n_done; m_mask = n_mask; m_en = n_en; m_rstp = n_rstp;
    for (int k = 0; k < 4; k++) m_err[k] = n_err[k];
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    reg_wr = 1; reg_addr = a; reg_wdata = d; tick(tag);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    reg_rd = 1; reg_addr = a; tick(tag);
  endtask

  task automatic pulse(input logic [NCH-1:0] d, b, r, x, o, input string tag);
    ev_done = d; ev_burst_to = b; ev_req_to = r; ev_xfer_err = x; ev_buf_ovf = o;
    tick(tag);
  endtask

  task automatic check_irq(input string tag);
    logic any_err;
    tick(tag);
    any_err = |{m_err[0], m_err[1], m_err[2], m_err[3]};
    check({tag, " irq_norm"}, {31'd0, irq_norm}, {31'd0, |(m_done & ~m_mask)});
    check({tag, " irq_err"}, {31'd0, irq_err}, {31'd0, any_err});
    check({tag, " mod_en"}, {31'd0, mod_en}, {31'd0, m_en});
  endtask

  // monitor: pops expected read data as results come out
  always @(negedge clk) begin
    if (!rst && reg_rvalid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R9 unexpected rvalid actual=%h expected=none", reg_rdata);
      end else begin
        check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done_run) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    idle_inputs();
    rst = 1;
    m_done = '0; m_mask = '1; m_en = 0; m_rstp = 0;
    for (int k = 0; k < 4; k++) m_err[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R1 reset state
    for (int a = 0; a < 8; a++) rd(8'(a*4), "R1 reset readback");
    check_irq("R1 reset outputs");

    // R3 disabled: events dropped
    pulse(16'hFFFF, 16'h0001, 16'h8000, 16'h00F0, 16'h0F00, "R3");
    rd(8'h04, "R3 done after disabled pulse");
    rd(8'h14, "R3 xfer err after disabled pulse");
    check_irq("R3 no irq");

    // R2 enable and set end channels
    wr(8'h00, 32'h1, "R2 enable");
    pulse(16'h8001, 0, 0, 0, 0, "R2");
    rd(8'h04, "R2 done bits 0 and 15");
    check_irq("R6 masked completion");
    wr(8'h08, 32'h0000FFFE, "R6 unmask ch0");
    check_irq("R6 unmasked ch0");
    wr(8'h08, 32'hFFFF7FFF, "R10 unmask ch15 with upper ones");
    rd(8'h08, "R10 mask upper bits");
    check_irq("R6 unmasked ch15");

    // R4 write-one-to-clear
    wr(8'h04, 32'h0000_0000, "R4 zero write");
    rd(8'h04, "R4 zero write keeps bits");
    wr(8'h04, 32'hFFFF_0001, "R4 clear ch0");
    rd(8'h04, "R4 ch0 cleared");
    check_irq("R6 ch15 still pending");
    wr(8'h04, 32'h0000_8000, "R4 clear ch15");
    check_irq("R6 line drops");

    // R2/R7 error banks
    pulse(0, 16'h0002, 16'h0040, 16'h0400, 16'h4000, "R2 errors");
    rd(8'h0C, "R2 burst bank"); rd(8'h10, "R2 request bank");
    rd(8'h14, "R2 transfer bank"); rd(8'h18, "R2 overflow bank");
    wr(8'h08, 32'hFFFF, "R7 mask all");
    check_irq("R7 error ignores mask");
    wr(8'h0C, 32'h2, "R4 clr burst"); wr(8'h10, 32'h40, "R4 clr req");
    wr(8'h14, 32'h400, "R4 clr xfer");
    check_irq("R7 one bank still set");
    wr(8'h18, 32'h4000, "R4 clr ovf");
    check_irq("R7 all clear");

    // R5 collision
    pulse(16'h0018, 0, 0, 0, 0, "R5 setup");
    reg_wr = 1; reg_addr = 8'h04; reg_wdata = 32'h0018; ev_done = 16'h0008;
    tick("R5 collide");
    rd(8'h04, "R5 event beats clear");
    reg_wr = 1; reg_addr = 8'h18; reg_wdata = 32'h1; ev_buf_ovf = 16'h1;
    tick("R5 collide ovf");
    rd(8'h18, "R5 ovf bank collide");

    // R9 unmapped and read-during-write
    wr(8'h1C, 32'hFFFFFFFF, "R9 unmapped write");
    wr(8'h40, 32'hFFFFFFFF, "R9 unmapped write");
    rd(8'h1C, "R9 unmapped read"); rd(8'h40, "R9 unmapped read");
    rd(8'h04, "R9 done untouched");
    reg_wr = 1; reg_rd = 1; reg_addr = 8'h08; reg_wdata = 32'h1234;
    tick("R9 read returns old value");
    rd(8'h08, "R9 new mask value");

    // R8 module reset request
    pulse(16'h00F0, 16'h1, 16'h2, 16'h4, 16'h8, "R8 setup");
    wr(8'h08, 32'h0, "R8 unmask all");
    wr(8'h00, 32'h3, "R8 request");
    reg_rd = 1; reg_addr = 8'h00; ev_done = 16'h0F00; ev_xfer_err = 16'h0100;
    tick("R8 request visible");
    for (int a = 0; a < 7; a++) rd(8'(a*4), "R8 after reset request");
    check_irq("R8 lines low");

    // mixed pattern
    wr(8'h08, 32'h00FF, "R6 mixed mask");
    lf = 16'hACE1;
    for (int i = 0; i < 60; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      ev_done = lf; ev_burst_to = lf & 16'h0F0F; ev_req_to = {lf[7:0], lf[15:8]};
      ev_xfer_err = lf & 16'h8421; ev_buf_ovf = ~lf & 16'h1248;
      reg_wr = lf[0]; reg_addr = 8'(4 * (1 + (lf[3:1] % 6)));
      reg_wdata = {16'd0, ~lf};
      reg_rd = lf[4]; 
      if (reg_addr == 8'h08) reg_addr = 8'h04;
      tick("R4 R5 mixed");
      rd(8'(4 * (lf[7:5] % 7)), "R2 mixed readback");
      if (i % 10 == 0) check_irq("R6 R7 mixed");
    end

    repeat (3) tick("drain");
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R9 missing read data actual=%0d expected=0", exp_q.size());
    end
    done_run = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule